// File: doc/BRIEF.md
# Two-Wire Bus Line Controller

This block watches a two-wire serial bus through already synchronized copies of its data (SDA) and clock (SCL) lines. It detects start conditions (SDA falling while SCL is high) and stop conditions (SDA rising while SCL is high). It keeps a sticky flag for each, and each flag is cleared by a one-cycle clear strobe. The start flag, gated by an enable, forms an interrupt request.

A slave that has just seen a start can stretch the bus clock. From the master's next SCL falling edge, the block keeps SCL pulled low until the start flag is cleared. In the overflow-hold mode it also keeps SCL low while the neighbouring bit counter reports an overflow.

The block also drives the two open-drain pull-low enables, built from the shift-register MSB, the port bits, the direction bits and the hold sources. It reports a collision when the transmitted MSB disagrees with the line. SDA passes through a parameterized delay line before start and stop evaluation, so SCL is sampled while it is still valid.

The 2-bit mode input selects how the block behaves:
- 00: off.
- 01: three-wire. The open-drain enables stay off.
- 10: two-wire.
- 11: two-wire with clock hold on counter overflow.

In modes 00 and 01, when the clock-select input has its upper bit set and the strobe-select input is 0, any SCL edge sets the start flag instead.

Top module: `tw_line_top`

## Requirements
- R1: In modes 10 and 11, SDA falling while SCL is high sets startFlag within 6 clock cycles. startFlag stays set until a cycle with clrStart high, after which it reads 0.
- R2: In modes 10 and 11, SDA rising while SCL is high sets stopFlag within 6 cycles, and clrStop clears it. A stop never raises startIrq.
- R3: startIrq is high exactly when startFlag and startIrqEn are both 1.
- R4: After a start in a two-wire mode, with sclDir=1 and sclPort=1, sclPullLow stays 0 until SCL falls. It then reads 1 until startFlag is cleared, and reads 0 again afterwards.
- R5: In mode 11, ovfFlag=1 with sclDir=1 drives sclPullLow to 1. In mode 10, ovfFlag has no effect on sclPullLow.
- R6: In modes 00 and 01, both sdaPullLow and sclPullLow are 0. With clkSel=00, SDA falling while SCL is high leaves startFlag at 0.
- R7: In modes 00 and 01, with clkSel[1]=1 and swStrobe=0, any SCL edge sets startFlag. With swStrobe=1, SCL edges leave it at 0.
- R8: In a two-wire mode, sdaPullLow = sdaDir AND (shiftMsb==0 OR sdaPort==0).
- R9: In a two-wire mode, sclPullLow is 1 only when sclDir=1, and then whenever sclPort=0.
- R10: collision is 1 in a two-wire mode when shiftMsb differs from sdaIn, and is 0 in modes 00 and 01.
- R11: After reset, startFlag, stopFlag, startIrq, sdaPullLow and sclPullLow are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sdaIn | input | 1 | Synchronized SDA line level |
| sclIn | input | 1 | Synchronized SCL line level |
| wireMode | input | 2 | 00 off, 01 three-wire, 10 two-wire, 11 two-wire with overflow hold |
| clkSel | input | 2 | Clock source select of the shift core |
| swStrobe | input | 1 | Strobe-select bit of the shift core |
| shiftMsb | input | 1 | Bit 7 of the shift register |
| sdaPort | input | 1 | Port output bit for SDA |
| sclPort | input | 1 | Port output bit for SCL |
| sdaDir | input | 1 | Direction bit for SDA (1 = driver enabled) |
| sclDir | input | 1 | Direction bit for SCL (1 = driver enabled) |
| ovfFlag | input | 1 | Counter overflow flag from the shift core |
| startIrqEn | input | 1 | Start interrupt enable |
| clrStart | input | 1 | Clear strobe for startFlag |
| clrStop | input | 1 | Clear strobe for stopFlag |
| startFlag | output | 1 | Sticky start flag |
| stopFlag | output | 1 | Sticky stop flag |
| startIrq | output | 1 | Start interrupt request |
| collision | output | 1 | Shift MSB differs from SDA line |
| sdaPullLow | output | 1 | Pull SDA low (open-drain enable) |
| sclPullLow | output | 1 | Pull SCL low (open-drain enable) |

## Verification
The bench checks that the clock stretch begins only at the master's SCL falling edge after a start, not at the start itself. A design that stretched at once would stall the master before it could lower the clock. It also checks that the stretch ends the cycle the flag is cleared; a stale hold would freeze the bus.

Mode gating gets its own tests. SDA falling while SCL is high in three-wire mode must not flag a start, while SCL edges with the edge-flag selection must flag one, and the strobe-select bit must mask them. The bench also checks that overflow holds the clock only in the overflow-hold mode, and that the direction bit masks every pull-low source. Other tests confirm that a stop never produces an interrupt and that collision stays quiet outside the two-wire modes.

// File: rtl/tw_line_pkg.sv
package tw_line_pkg;
  localparam logic [1:0] MODE_OFF    = 2'b00;
  localparam logic [1:0] MODE_3W     = 2'b01;
  localparam logic [1:0] MODE_2W     = 2'b10;
  localparam logic [1:0] MODE_2W_OVF = 2'b11;

  typedef struct packed {
    logic startCond;
    logic stopCond;
    logic sclFall;
    logic sclEdge;
  } lineEvt_t;
endpackage

// File: rtl/tw_line_path.sv
module tw_line_path
  import tw_line_pkg::*;
#(
  parameter int SDA_DLY = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sdaIn,
  input  logic     sclIn,
  output lineEvt_t evt
);
  localparam int LAST = SDA_DLY - 1;

  logic [SDA_DLY-1:0] sdaPipe;
  logic sdaDlyPrev;
  logic sclPrev;

  generate
    for (genvar k = 0; k < SDA_DLY; k++) begin : g_dly
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) sdaPipe[k] <= 1'b1;
          else       sdaPipe[k] <= sdaIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) sdaPipe[k] <= 1'b1;
          else       sdaPipe[k] <= sdaPipe[k-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaDlyPrev <= 1'b1;
      sclPrev    <= 1'b1;
    end else begin
      sdaDlyPrev <= sdaPipe[LAST];
      sclPrev    <= sclIn;
    end
  end

  always_comb begin
    evt.startCond = sclIn & sdaDlyPrev & ~sdaPipe[LAST];
    evt.stopCond  = sclIn & ~sdaDlyPrev & sdaPipe[LAST];
    evt.sclFall   = sclPrev & ~sclIn;
    evt.sclEdge   = sclPrev ^ sclIn;
  end
endmodule

// File: rtl/tw_line_ctl.sv
module tw_line_ctl
  import tw_line_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lineEvt_t   evt,
  input  logic       sdaIn,
  input  logic [1:0] wireMode,
  input  logic [1:0] clkSel,
  input  logic       swStrobe,
  input  logic       shiftMsb,
  input  logic       sdaPort,
  input  logic       sclPort,
  input  logic       sdaDir,
  input  logic       sclDir,
  input  logic       ovfFlag,
  input  logic       startIrqEn,
  input  logic       clrStart,
  input  logic       clrStop,
  output logic       startFlag,
  output logic       stopFlag,
  output logic       startIrq,
  output logic       collision,
  output logic       sdaPullLow,
  output logic       sclPullLow
);
  logic twoWire, edgeFlagMode, setStart, setStop;
  logic startNext, holdNext, startHold, ovfHold;

  always_comb begin
    twoWire      = wireMode[1];
    edgeFlagMode = ~twoWire & clkSel[1] & ~swStrobe;
    setStart     = (twoWire & evt.startCond) | (edgeFlagMode & evt.sclEdge);
    setStop      = twoWire & evt.stopCond;
    startNext    = setStart | (startFlag & ~clrStart);
    holdNext     = twoWire & startNext & (startHold | evt.sclFall);
    ovfHold      = (wireMode == MODE_2W_OVF) & ovfFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startFlag <= 1'b0;
      stopFlag  <= 1'b0;
      startHold <= 1'b0;
    end else begin
      startFlag <= startNext;
      stopFlag  <= setStop | (stopFlag & ~clrStop);
      startHold <= holdNext;
    end
  end

  always_comb begin
    startIrq   = startFlag & startIrqEn;
    collision  = twoWire & (shiftMsb ^ sdaIn);
    sdaPullLow = twoWire & sdaDir & (~shiftMsb | ~sdaPort);
    sclPullLow = twoWire & sclDir & (~sclPort | startHold | ovfHold);
  end

  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrStart && !setStart) |=> !startFlag);

  // R2
  stop_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    setStop |=> stopFlag);

  // R4
  hold_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startHold) |-> $past(evt.sclFall));

  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wireMode == MODE_2W_OVF && ovfFlag && sclDir) |-> sclPullLow);

  // R6
  quiet_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wireMode[1] |-> (!sdaPullLow && !sclPullLow));
endmodule

// File: rtl/tw_line_top.sv
module tw_line_top
  import tw_line_pkg::*;
#(
  parameter int SDA_DLY = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaIn,
  input  logic       sclIn,
  input  logic [1:0] wireMode,
  input  logic [1:0] clkSel,
  input  logic       swStrobe,
  input  logic       shiftMsb,
  input  logic       sdaPort,
  input  logic       sclPort,
  input  logic       sdaDir,
  input  logic       sclDir,
  input  logic       ovfFlag,
  input  logic       startIrqEn,
  input  logic       clrStart,
  input  logic       clrStop,
  output logic       startFlag,
  output logic       stopFlag,
  output logic       startIrq,
  output logic       collision,
  output logic       sdaPullLow,
  output logic       sclPullLow
);
  lineEvt_t evt;

  tw_line_path #(.SDA_DLY(SDA_DLY)) i_path (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .sclIn(sclIn), .evt(evt)
  );

  tw_line_ctl i_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .sdaIn(sdaIn),
    .wireMode(wireMode), .clkSel(clkSel), .swStrobe(swStrobe),
    .shiftMsb(shiftMsb), .sdaPort(sdaPort), .sclPort(sclPort),
    .sdaDir(sdaDir), .sclDir(sclDir), .ovfFlag(ovfFlag),
    .startIrqEn(startIrqEn), .clrStart(clrStart), .clrStop(clrStop),
    .startFlag(startFlag), .stopFlag(stopFlag), .startIrq(startIrq),
    .collision(collision), .sdaPullLow(sdaPullLow), .sclPullLow(sclPullLow)
  );
endmodule

// File: tb/test_tw_line_top.sv
module test_tw_line_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sdaIn = 1'b1, sclIn = 1'b1;
  logic [1:0] wireMode = 2'b00, clkSel = 2'b00;
  logic swStrobe = 1'b0, shiftMsb = 1'b1, sdaPort = 1'b1, sclPort = 1'b1;
  logic sdaDir = 1'b1, sclDir = 1'b1, ovfFlag = 1'b0, startIrqEn = 1'b0;
  logic clrStart = 1'b0, clrStop = 1'b0;
  logic startFlag, stopFlag, startIrq, collision, sdaPullLow, sclPullLow;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tw_line_top i_tw_line_top (.*);

  // mode[11:10] msb sdaPort sclPort sdaDir sclDir sdaIn ovf | expSda expScl expColl
  localparam logic [11:0] VEC [12] = '{
    12'b10_1111110_000, 12'b10_0111100_100, 12'b10_1011100_101,
    12'b10_0110110_001, 12'b10_1101110_010, 12'b10_1101010_000,
    12'b10_1111111_000, 12'b11_1111111_010, 12'b11_1111011_000,
    12'b01_0001111_000, 12'b00_0001110_000, 12'b11_0111100_100
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseClr(input bit stopSide);
    @(negedge clk);
    if (stopSide) clrStop = 1'b1; else clrStart = 1'b1;
    @(negedge clk);
    clrStop = 1'b0;
    clrStart = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    // R11 reset state
    chk("R11 startFlag", startFlag, 1'b0);
    chk("R11 stopFlag", stopFlag, 1'b0);
    chk("R11 startIrq", startIrq, 1'b0);
    chk("R11 sdaPullLow", sdaPullLow, 1'b0);
    chk("R11 sclPullLow", sclPullLow, 1'b0);

    // vector table, SCL held low so no start or stop occurs
    sclIn = 1'b0;
    cyc(2);
    foreach (VEC[i]) begin
      @(negedge clk);
      {wireMode, shiftMsb, sdaPort, sclPort, sdaDir, sclDir, sdaIn, ovfFlag} = VEC[i][11:3];
      #2;
      chk("R8 sdaPullLow", sdaPullLow, VEC[i][2]);
      chk("R9 R5 sclPullLow", sclPullLow, VEC[i][1]);
      chk("R10 collision", collision, VEC[i][0]);
    end

    // start, stretch and release
    wireMode = 2'b10; shiftMsb = 1'b1; sdaPort = 1'b1; sclPort = 1'b1;
    sdaDir = 1'b1; sclDir = 1'b1; ovfFlag = 1'b0; startIrqEn = 1'b0;
    sdaIn = 1'b1; sclIn = 1'b1;
    cyc(5);
    sdaIn = 1'b0;
    cyc(6);
    chk("R1 start set", startFlag, 1'b1);
    chk("R3 irq masked", startIrq, 1'b0);
    chk("R4 no hold before fall", sclPullLow, 1'b0);
    startIrqEn = 1'b1;
    #2;
    chk("R3 irq enabled", startIrq, 1'b1);
    sclIn = 1'b0;
    cyc(3);
    chk("R4 hold after fall", sclPullLow, 1'b1);
    cyc(8);
    chk("R1 start sticky", startFlag, 1'b1);
    chk("R4 hold kept", sclPullLow, 1'b1);
    pulseClr(1'b0);
    cyc(1);
    chk("R1 start cleared", startFlag, 1'b0);
    chk("R4 hold released", sclPullLow, 1'b0);
    chk("R3 irq drops", startIrq, 1'b0);

    // stop condition
    sclIn = 1'b1;
    cyc(5);
    sdaIn = 1'b1;
    cyc(6);
    chk("R2 stop set", stopFlag, 1'b1);
    chk("R2 stop no irq", startIrq, 1'b0);
    pulseClr(1'b1);
    cyc(1);
    chk("R2 stop cleared", stopFlag, 1'b0);

    // three-wire mode: no start detection, no pulls
    wireMode = 2'b01; clkSel = 2'b00; sdaPort = 1'b0; sclPort = 1'b0;
    cyc(3);
    sdaIn = 1'b0;
    cyc(6);
    chk("R6 no start in 01", startFlag, 1'b0);
    chk("R6 sda quiet", sdaPullLow, 1'b0);
    chk("R6 scl quiet", sclPullLow, 1'b0);
    sdaIn = 1'b1;
    sdaPort = 1'b1; sclPort = 1'b1;
    cyc(4);

    // edge flagging in modes 01 and 00
    clkSel = 2'b10; swStrobe = 1'b0;
    cyc(2);
    sclIn = 1'b0;
    cyc(3);
    chk("R7 edge sets flag 01", startFlag, 1'b1);
    pulseClr(1'b0);
    cyc(1);
    swStrobe = 1'b1;
    cyc(1);
    sclIn = 1'b1;
    cyc(3);
    chk("R7 strobe masks edge", startFlag, 1'b0);
    wireMode = 2'b00; clkSel = 2'b11; swStrobe = 1'b0;
    cyc(2);
    sclIn = 1'b0;
    cyc(3);
    chk("R7 edge sets flag 00", startFlag, 1'b1);
    pulseClr(1'b0);
    cyc(1);
    chk("R1 clear in 00", startFlag, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule